// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's load/store port and a slower next-level memory. Every request is looked up in one cycle. The lookup picks exactly one line: the block address taken modulo the number of lines. A hit returns the addressed word in the same cycle, and a store hit updates only the cache. A miss raises a stall toward the processor. If the victim line is dirty, the controller first writes that whole block back. It then reads the whole missing block from memory and installs it. After that it performs the original access as a hit.

The processor holds its request (`cpu_req`, `cpu_we`, `cpu_addr`, `cpu_wdata`) steady while `cpu_stall` is high. The access is complete in the first cycle in which `cpu_req` is high and `cpu_stall` is low. A store commits on that cycle's clock edge.

The memory side moves one whole block per transaction. The controller raises `mem_req` with a block-aligned `mem_addr` and the direction on `mem_we`, then holds them until a one-cycle `mem_ack`. On a read, `mem_rblock` is sampled in the ack cycle. On a write, `mem_wblock` carries the victim block. Word *i* of a block occupies bits `[i*WORD_W +: WORD_W]`.

The controller has three states:
- `ST_LOOKUP`: idle and hit handling.
- `ST_EVICT`: write-back of a dirty victim.
- `ST_REFILL`: block read.

The transitions are:
- `ST_LOOKUP` goes to `ST_EVICT` on a miss whose line is valid and dirty.
- `ST_LOOKUP` goes to `ST_REFILL` on a miss whose line is clean or invalid.
- `ST_EVICT` goes to `ST_REFILL` on `mem_ack`.
- `ST_REFILL` goes back to `ST_LOOKUP` on `mem_ack`, where the held request now hits.

Top module: `dm_wb_cache`

## Requirements
- R1: With the default geometry (256 lines of 4 words of 32 bits), address bits [1:0] are ignored, bits [3:2] select the word within the block, bits [11:4] select the line and bits [31:12] are the tag; two addresses that differ only in bits [1:0] return the same word.
- R2: After reset every line is invalid, `cpu_stall` is low while no request is present and `mem_req` is low.
- R3: A request whose line is valid and whose stored tag equals the address tag returns the word on `cpu_rdata` with `cpu_stall` low in the same cycle and causes no memory transaction.
- R4: A load miss raises `cpu_stall` in its first cycle, reads the entire block from memory, and then returns the requested word with `cpu_stall` low.
- R5: A store hit changes only the cached word and marks the line dirty; memory is not written at that time, and later loads return the stored value.
- R6: On a miss to a dirty line, the old block is written to memory at its own block address before the fill read is issued; a miss to a clean line writes nothing back.
- R7: A store miss first fills the whole block from memory and then writes the store word; the other words of that line hold memory contents of the new block.
- R8: `mem_req`, `mem_we` and `mem_addr` stay constant from the rise of `mem_req` until `mem_ack`, and each miss performs exactly one block read.
- R9: Two blocks with the same line index and different tags, accessed alternately, miss on every access.
- R10: With 4 lines of one word, the word reference sequence 0 1 2 3 4 3 4 15 gives 6 misses in 8 accesses; with 4 lines of two words it gives 4 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | WORD_W | Store data |
| cpu_rdata | output | WORD_W | Load data, valid when request high and stall low |
| cpu_stall | output | 1 | Access not complete; hold the request |
| mem_req | output | 1 | Block transaction request to next level |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W | Block-aligned address of the transaction |
| mem_wblock | output | WORDS*WORD_W | Victim block data for a write-back |
| mem_rblock | input | WORDS*WORD_W | Block read data, sampled with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the transaction |

## Verification
A vector table replays a fixed load/store walk on the default geometry. The walk is arranged to separate the cases:
- a cold miss from a hit in a freshly filled block;
- a store hit from a store miss, where the other words of the line must come from memory;
- a dirty eviction from a clean eviction, by counting write-backs per access.

Directed runs then set a store hit against the memory image to show nothing was written through, and probe byte offsets inside a word. Two alternating conflicting blocks show that the controller never keeps both. Two small geometries replay the same word sequence, and their miss counts differ only because of block size.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 2,
    parameter int OFF_W  = 2,
    parameter int WSEL_W = 2,
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WSEL_W-1:0] wsel
);
    logic unused_byte_bits;
    assign unused_byte_bits = ^addr[BYTE_W-1:0];

    assign idx = addr[BYTE_W+OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];

    generate
        if (OFF_W > 0) begin : g_multi_word
            assign wsel = addr[BYTE_W +: OFF_W];
        end else begin : g_single_word
            assign wsel = '0;
        end
    endgenerate
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             install,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= new_tag;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

    // R5
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |-> valid_q[idx]);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int LINES  = 256,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 8,
    parameter int WSEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WSEL_W-1:0]       wsel,
    input  logic                    fill_en,
    input  logic [WORDS*WORD_W-1:0] fill_block,
    input  logic                    word_en,
    input  logic [WORD_W-1:0]       word_data,
    output logic [WORD_W-1:0]       rd_word,
    output logic [WORDS*WORD_W-1:0] rd_block
);
    localparam int BLK_W = WORDS * WORD_W;

    logic [BLK_W-1:0] blk_q [LINES];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            blk_q[idx] <= fill_block;
        end else if (word_en) begin
            blk_q[idx][int'(wsel)*WORD_W +: WORD_W] <= word_data;
        end
    end

    assign rd_block = blk_q[idx];
    assign rd_word  = rd_block[int'(wsel)*WORD_W +: WORD_W];

    // R7
    fill_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && word_en));
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int LINES  = 256,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    cpu_stall,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORDS*WORD_W-1:0] mem_wblock,
    input  logic [WORDS*WORD_W-1:0] mem_rblock,
    input  logic                    mem_ack
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int IDX_W  = $clog2(LINES);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int WSEL_W = (OFF_W > 0) ? OFF_W : 1;
    localparam int LOW_W  = BYTE_W + OFF_W;
    localparam int TAG_W  = ADDR_W - LOW_W - IDX_W;

    dmc_state_e state_q, state_d;

    logic [TAG_W-1:0]  req_tag, line_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic              line_valid, line_dirty, hit;
    logic              install, word_wr;

    dmc_addr_split #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .OFF_W(OFF_W),
        .WSEL_W(WSEL_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split (
        .addr(cpu_addr), .tag(req_tag), .idx(req_idx), .wsel(req_wsel)
    );

    dmc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(req_idx),
        .install(install), .new_tag(req_tag), .mark_dirty(word_wr),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag)
    );

    dmc_data_store #(
        .LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W),
        .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_data (
        .clk(clk), .rst_n(rst_n), .idx(req_idx), .wsel(req_wsel),
        .fill_en(install), .fill_block(mem_rblock),
        .word_en(word_wr), .word_data(cpu_wdata),
        .rd_word(cpu_rdata), .rd_block(mem_wblock)
    );

    assign hit = line_valid && (line_tag == req_tag);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (cpu_req && !hit)
                           state_d = (line_valid && line_dirty) ? ST_EVICT : ST_REFILL;
            ST_EVICT:  if (mem_ack) state_d = ST_REFILL;
            ST_REFILL: if (mem_ack) state_d = ST_LOOKUP;
            default:   state_d = ST_LOOKUP;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_stall = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, req_idx, {LOW_W{1'b0}}};
        install   = 1'b0;
        word_wr   = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_stall = cpu_req && !hit;
                word_wr   = cpu_req && cpu_we && hit;
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {line_tag, req_idx, {LOW_W{1'b0}}};
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                install = mem_ack;
            end
            default: cpu_stall = 1'b1;
        endcase
    end

    // R8
    memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R6
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R6
    evict_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (line_valid && line_dirty));

    // R4
    refill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (!cpu_req || !$stable(cpu_addr) || !cpu_stall));
endmodule

// File: tb/test_dm_wb_cache.sv
module cache_harness #(
    parameter int LINES = 256,
    parameter int WORDS = 4
) (
    input logic clk,
    input logic rst_n
);
    localparam int DEPTH = 2048;
    localparam int LAT   = 3;

    logic                 cpu_req   = 1'b0;
    logic                 cpu_we    = 1'b0;
    logic [31:0]          cpu_addr  = '0;
    logic [31:0]          cpu_wdata = '0;
    logic [31:0]          cpu_rdata;
    logic                 cpu_stall;
    logic                 mem_req, mem_we, mem_ack;
    logic [31:0]          mem_addr;
    logic [WORDS*32-1:0]  mem_wblock, mem_rblock;
    logic [31:0]          mem [DEPTH];
    int                   wb_cnt, rd_cnt, cnt;

    dm_wb_cache #(.ADDR_W(32), .WORD_W(32), .LINES(LINES), .WORDS(WORDS)) i_dm_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wblock(mem_wblock), .mem_rblock(mem_rblock), .mem_ack(mem_ack)
    );

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'hA000_0000 + i;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack    <= 1'b0;
            cnt        <= 0;
            wb_cnt     <= 0;
            rd_cnt     <= 0;
            mem_rblock <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (cnt == LAT) begin
                cnt     <= 0;
                mem_ack <= 1'b1;
                for (int w = 0; w < WORDS; w++) begin
                    if (mem_we) mem[(int'(mem_addr[12:2]) + w) % DEPTH] <= mem_wblock[w*32 +: 32];
                    else mem_rblock[w*32 +: 32] <= mem[(int'(mem_addr[12:2]) + w) % DEPTH];
                end
                if (mem_we) wb_cnt <= wb_cnt + 1;
                else        rd_cnt <= rd_cnt + 1;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic miss, output int wbs);
        int wb0;
        int n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        wb0 = wb_cnt;
        #1;
        miss = cpu_stall;
        n = 0;
        while (cpu_stall && n < 2000) begin
            @(negedge clk); #1; n++;
        end
        rd  = cpu_rdata;
        wbs = wb_cnt - wb0;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask
endmodule

module test_dm_wb_cache;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_harness #(.LINES(256), .WORDS(4)) h_main (.clk(clk), .rst_n(rst_n));
    cache_harness #(.LINES(4),   .WORDS(1)) h_w1   (.clk(clk), .rst_n(rst_n));
    cache_harness #(.LINES(4),   .WORDS(2)) h_w2   (.clk(clk), .rst_n(rst_n));

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        chk;
        logic        miss;
        logic [1:0]  wbs;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b0, 32'h0000, 32'h0,         32'hA000_0000, 1'b1, 1'b1, 2'd0},
        '{1'b0, 32'h0004, 32'h0,         32'hA000_0001, 1'b1, 1'b0, 2'd0},
        '{1'b1, 32'h0008, 32'h1111_1111, 32'h0,         1'b0, 1'b0, 2'd0},
        '{1'b0, 32'h0008, 32'h0,         32'h1111_1111, 1'b1, 1'b0, 2'd0},
        '{1'b0, 32'h1008, 32'h0,         32'hA000_0402, 1'b1, 1'b1, 2'd1},
        '{1'b0, 32'h0008, 32'h0,         32'h1111_1111, 1'b1, 1'b1, 2'd0},
        '{1'b1, 32'h0104, 32'h2222_2222, 32'h0,         1'b0, 1'b1, 2'd0},
        '{1'b0, 32'h0100, 32'h0,         32'hA000_0040, 1'b1, 1'b0, 2'd0},
        '{1'b0, 32'h0104, 32'h0,         32'h2222_2222, 1'b1, 1'b0, 2'd0},
        '{1'b0, 32'h1104, 32'h0,         32'hA000_0441, 1'b1, 1'b1, 2'd1},
        '{1'b0, 32'h0104, 32'h0,         32'h2222_2222, 1'b1, 1'b1, 2'd0},
        '{1'b0, 32'h010C, 32'h0,         32'hA000_0043, 1'b1, 1'b0, 2'd0},
        '{1'b0, 32'h0003, 32'h0,         32'hA000_0000, 1'b1, 1'b0, 2'd0}
    };

    localparam int SEQ [8] = '{0, 1, 2, 3, 4, 3, 4, 15};

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R4 watchdog: actual=hung expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic        miss;
        int          wbs;
        int          misses;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2: reset state
        check("R2", "stall idle", {31'd0, h_main.cpu_stall}, 32'd0);
        check("R2", "mem_req idle", {31'd0, h_main.mem_req}, 32'd0);

        // Vector walk: R1 R3 R4 R5 R6 R7
        for (int i = 0; i < 13; i++) begin
            h_main.access(VEC[i].we, VEC[i].addr, VEC[i].wdata, rd, miss, wbs);
            check("R3/R4", $sformatf("vec %0d miss", i), {31'd0, miss}, {31'd0, VEC[i].miss});
            check("R6", $sformatf("vec %0d writebacks", i), wbs, {30'd0, VEC[i].wbs});
            if (VEC[i].chk)
                check("R1/R5/R7", $sformatf("vec %0d data", i), rd, VEC[i].exp);
        end
        // R8: one block read per miss (6 misses in the walk)
        check("R8", "block reads", h_main.rd_cnt, 32'd6);
        // R6: write-back carried store data to memory
        check("R6", "memory word 0x41", h_main.mem[32'h41], 32'h2222_2222);

        // R1: byte offset within word 3 is ignored
        h_main.access(1'b0, 32'h000E, 32'h0, rd, miss, wbs);
        check("R1", "byte offset data", rd, 32'hA000_0003);
        check("R1", "byte offset hit", {31'd0, miss}, 32'd0);

        // R5: store hit leaves memory untouched
        h_main.access(1'b1, 32'h010C, 32'h3333_3333, rd, miss, wbs);
        check("R5", "store hit miss", {31'd0, miss}, 32'd0);
        check("R5", "store hit writebacks", wbs, 32'd0);
        check("R5", "memory unchanged", h_main.mem[32'h43], 32'hA000_0043);
        h_main.access(1'b0, 32'h010C, 32'h0, rd, miss, wbs);
        check("R5", "readback", rd, 32'h3333_3333);

        // R9: alternate conflicting blocks on line 0
        misses = 0;
        for (int k = 0; k < 6; k++) begin
            h_main.access(1'b0, (k % 2 == 0) ? 32'h1000 : 32'h0000, 32'h0, rd, miss, wbs);
            misses += int'(miss);
        end
        check("R9", "conflict misses default", misses, 32'd6);

        // R10: reference sequence, one-word blocks
        misses = 0;
        for (int k = 0; k < 8; k++) begin
            h_w1.access(1'b0, 32'(SEQ[k] * 4), 32'h0, rd, miss, wbs);
            misses += int'(miss);
            check("R10", $sformatf("w1 data %0d", k), rd, 32'hA000_0000 + 32'(SEQ[k]));
        end
        check("R10", "one-word misses", misses, 32'd6);

        // R10: reference sequence, two-word blocks
        misses = 0;
        for (int k = 0; k < 8; k++) begin
            h_w2.access(1'b0, 32'(SEQ[k] * 4), 32'h0, rd, miss, wbs);
            misses += int'(miss);
        end
        check("R10", "two-word misses", misses, 32'd4);

        // R9: ping-pong on words 0 and 4, one-word blocks
        misses = 0;
        for (int k = 0; k < 8; k++) begin
            h_w1.access(1'b0, (k % 2 == 0) ? 32'h0 : 32'h10, 32'h0, rd, miss, wbs);
            misses += int'(miss);
        end
        check("R9", "ping-pong misses", misses, 32'd8);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule